// File: doc/BRIEF.md
# Hidden DAC Command Register Sequencer

This block sits on an 8-bit register bus next to a RAMDAC model. It watches accesses to the pixel-mask port (offset 6). Software reads that port a set number of times in a row to unlock it. After the unlock, the same port no longer reaches the ordinary mask register. It reaches a hidden command register instead, and it stays that way until any access to the write-index port (offset 8) clears the read counter again.

The top three bits of the command register choose the colour mode. The block decodes them into one-hot mode flags, a pixel-clock divisor and a flag that asks for the pixel clock to be scaled by two thirds. These outputs are registered. A hidden register that reads back as zero is first filled with the power-on default 0x80, and that value is returned.

Top module: `dacseq_top`

## Requirements
- R1: While the read counter is below 4, a read of offset 6 increments the counter and returns the mask register.
- R2: While the counter equals 4, a read of offset 6 returns the command register and leaves the counter at 4, so repeated reads keep returning the command register.
- R3: While the counter equals 4 and the command register holds zero, a read of offset 6 loads 0x80 into it and returns 0x80.
- R4: While the counter equals 4, a write to offset 6 updates the command register and leaves the mask register unchanged.
- R5: A read or a write of offset 8 clears the counter to zero.
- R6: While the counter is below 4, a write to offset 6 updates the mask register and leaves the counter unchanged.
- R7: Command bits 7:5 = 3'b101 select 15-bit colour (mode_oh bit 1) with divisor 2. Command bits 7:5 = 3'b111 select 16-bit colour (mode_oh bit 2) with divisor 2.
- R8: Command bits 7:5 = 3'b011 select 24-bit colour (mode_oh bit 3) with divisor 3, and they raise clk_scale23.
- R9: Every other value of command bits 7:5, including the reset value 0, selects standard mode (mode_oh bit 0) with divisor 1 and clk_scale23 low. mode_oh always has exactly one bit set.
- R10: rdata is registered and changes on the edge that samples a read, and it holds its value at other times. A read of an offset other than 6 returns 0x00 and leaves the counter unchanged. When both strobes are high together, the access counts as a write only. The mode outputs follow a change of the command register one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_off | input | 4 | Register port offset |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| mode_oh | output | 4 | One-hot mode: bit0 standard, bit1 15-bit, bit2 16-bit, bit3 24-bit |
| clk_div | output | 2 | Pixel clock divisor (1, 2 or 3) |
| clk_scale23 | output | 1 | Pixel clock to be scaled by two thirds |

## Verification
If the counter holds a wrong value, the fault shows on the very next read of offset 6: the read returns the mask where the command register was expected, or the reverse. A command register that was loaded wrongly is hidden until the port is unlocked. It still shows one clock after the write, through the mode flags, the divisor and the scale flag. A missed default fill shows as 0x00 on the first unlocked read.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;
  localparam int NMODES   = 4;
  localparam int M_STD    = 0;
  localparam int M_RGB15  = 1;
  localparam int M_RGB16  = 2;
  localparam int M_RGB24  = 3;
  localparam logic [2:0] SEL_RGB15 = 3'b101;
  localparam logic [2:0] SEL_RGB16 = 3'b111;
  localparam logic [2:0] SEL_RGB24 = 3'b011;
endpackage

// File: rtl/dacseq_rstsync.sv
module dacseq_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= {sr_q[0], 1'b1};
  end
  assign rst_sync_n = sr_q[1];
endmodule

// File: rtl/dacseq_unlock.sv
module dacseq_unlock #(
  parameter int AW         = 4,
  parameter int MASK_OFF   = 6,
  parameter int IDX_OFF    = 8,
  parameter int UNLOCK_CNT = 4,
  localparam int CW        = $clog2(UNLOCK_CNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] off,
  input  logic          rd,
  input  logic          wr,
  output logic          unlocked
);
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          cnt_en;
  logic          hit_idx, hit_mask, rd_only;

  assign hit_idx  = (off == AW'(IDX_OFF));
  assign hit_mask = (off == AW'(MASK_OFF));
  assign rd_only  = rd & ~wr;
  assign unlocked = (cnt_q == CW'(UNLOCK_CNT));

  always_comb begin
    cnt_en = 1'b0;
    cnt_nx = cnt_q;
    if ((rd | wr) && hit_idx) begin
      cnt_en = 1'b1;
      cnt_nx = '0;
    end else if (rd_only && hit_mask && !unlocked) begin
      cnt_en = 1'b1;
      cnt_nx = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(UNLOCK_CNT));
  p_idx_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd | wr) && hit_idx) |=> (cnt_q == '0));
  p_unlock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && rd_only && hit_mask) |=> unlocked);
  p_wr_keeps_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_mask) |=> $stable(cnt_q));
endmodule

// File: rtl/dacseq_regs.sv
module dacseq_regs #(
  parameter int          AW       = 4,
  parameter int          DW       = 8,
  parameter int          MASK_OFF = 6,
  parameter logic [DW-1:0] CMD_DEFAULT = 8'h80,
  parameter logic [DW-1:0] MASK_RST    = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] off,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          unlocked,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] cmd
);
  logic [DW-1:0] mask_q, mask_nx, cmd_q, cmd_nx, rd_q, rd_nx;
  logic          mask_en, cmd_en, rd_en;
  logic          hit_mask, rd_only, cmd_zero;

  assign hit_mask = (off == AW'(MASK_OFF));
  assign rd_only  = rd & ~wr;
  assign cmd_zero = (cmd_q == '0);

  always_comb begin
    mask_en = wr && hit_mask && !unlocked;
    mask_nx = wdata;
    cmd_en  = 1'b0;
    cmd_nx  = cmd_q;
    if (wr && hit_mask && unlocked) begin
      cmd_en = 1'b1;
      cmd_nx = wdata;
    end else if (rd_only && hit_mask && unlocked && cmd_zero) begin
      cmd_en = 1'b1;
      cmd_nx = CMD_DEFAULT;
    end
    rd_en = rd_only;
    if (!hit_mask)     rd_nx = '0;
    else if (!unlocked) rd_nx = mask_q;
    else if (cmd_zero)  rd_nx = CMD_DEFAULT;
    else                rd_nx = cmd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
      cmd_q  <= '0;
      rd_q   <= '0;
    end else begin
      if (mask_en) mask_q <= mask_nx;
      if (cmd_en)  cmd_q  <= cmd_nx;
      if (rd_en)   rd_q   <= rd_nx;
    end
  end

  assign rdata = rd_q;
  assign cmd   = cmd_q;

  p_default_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && hit_mask && unlocked && cmd_zero) |=> (cmd_q == CMD_DEFAULT && rd_q == CMD_DEFAULT));
  p_mask_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_mask && unlocked) |=> $stable(mask_q));
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_only |=> $stable(rd_q));
endmodule

// File: rtl/dacseq_decode.sv
module dacseq_decode
  import dacseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     cmd,
  output logic [NMODES-1:0] mode_oh,
  output logic [1:0]        clk_div,
  output logic              scale23
);
  logic [2:0]        sel;
  logic [NMODES-1:0] mode_q, mode_nx;
  logic [1:0]        div_q, div_nx;
  logic              sc_q, sc_nx;

  assign sel = cmd[DW-1 -: 3];

  always_comb begin
    mode_nx = '0;
    div_nx  = 2'd1;
    sc_nx   = 1'b0;
    case (sel)
      SEL_RGB15: begin mode_nx[M_RGB15] = 1'b1; div_nx = 2'd2; end
      SEL_RGB16: begin mode_nx[M_RGB16] = 1'b1; div_nx = 2'd2; end
      SEL_RGB24: begin mode_nx[M_RGB24] = 1'b1; div_nx = 2'd3; sc_nx = 1'b1; end
      default:   mode_nx[M_STD] = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= NMODES'(1) << M_STD;
      div_q  <= 2'd1;
      sc_q   <= 1'b0;
    end else begin
      mode_q <= mode_nx;
      div_q  <= div_nx;
      sc_q   <= sc_nx;
    end
  end

  assign mode_oh = mode_q;
  assign clk_div = div_q;
  assign scale23 = sc_q;

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_q) == 1);
  p_rgb15_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_RGB15) |=> (mode_q[M_RGB15] && div_q == 2'd2));
  p_rgb24_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_RGB24) |=> (mode_q[M_RGB24] && div_q == 2'd3 && sc_q));
endmodule

// File: rtl/dacseq_top.sv
module dacseq_top
  import dacseq_pkg::*;
#(
  parameter int AW         = 4,
  parameter int DW         = 8,
  parameter int MASK_OFF   = 6,
  parameter int IDX_OFF    = 8,
  parameter int UNLOCK_CNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_off,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NMODES-1:0] mode_oh,
  output logic [1:0]        clk_div,
  output logic              clk_scale23
);
  logic          rst_i_n;
  logic          unlocked;
  logic [DW-1:0] cmd;

  dacseq_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  dacseq_unlock #(.AW(AW), .MASK_OFF(MASK_OFF), .IDX_OFF(IDX_OFF),
                  .UNLOCK_CNT(UNLOCK_CNT)) u_unlock (
    .clk(clk), .rst_n(rst_i_n), .off(bus_off), .rd(bus_rd), .wr(bus_wr),
    .unlocked(unlocked));

  dacseq_regs #(.AW(AW), .DW(DW), .MASK_OFF(MASK_OFF)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .off(bus_off), .rd(bus_rd), .wr(bus_wr),
    .wdata(bus_wdata), .unlocked(unlocked), .rdata(bus_rdata), .cmd(cmd));

  dacseq_decode #(.DW(DW)) u_dec (
    .clk(clk), .rst_n(rst_i_n), .cmd(cmd), .mode_oh(mode_oh),
    .clk_div(clk_div), .scale23(clk_scale23));
endmodule

// File: tb/sim_dacseq_top.sv
`timescale 1ns/1ps
module sim_dacseq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_off = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] mode_oh;
  logic [1:0] clk_div;
  logic       clk_scale23;

  int n_cmp = 0, n_bad = 0;
  int m_cnt = 0;
  logic [7:0] m_mask = 8'hFF, m_cmd = 8'h00;

  always #2.5 clk = ~clk;

  dacseq_top u0 (.clk(clk), .rst_n(rst_n), .bus_off(bus_off), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mode_oh(mode_oh), .clk_div(clk_div), .clk_scale23(clk_scale23));

  function automatic logic [3:0] f_mode(input logic [7:0] c);
    case (c[7:5])
      3'b101:  return 4'b0010;
      3'b111:  return 4'b0100;
      3'b011:  return 4'b1000;
      default: return 4'b0001;
    endcase
  endfunction
  function automatic logic [1:0] f_div(input logic [7:0] c);
    case (c[7:5])
      3'b101, 3'b111: return 2'd2;
      3'b011:         return 2'd3;
      default:        return 2'd1;
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_rd(input logic [3:0] off, input string tag_in);
    logic [7:0] exp;
    string tag;
    @(negedge clk);
    bus_off = off; bus_rd = 1'b1; bus_wr = 1'b0;
    if (off == 4'd8) begin exp = 8'h00; m_cnt = 0; tag = "R5"; end
    else if (off != 4'd6) begin exp = 8'h00; tag = "R10"; end
    else if (m_cnt < 4) begin exp = m_mask; m_cnt++; tag = "R1"; end
    else if (m_cmd == 8'h00) begin m_cmd = 8'h80; exp = 8'h80; tag = "R3"; end
    else begin exp = m_cmd; tag = "R2"; end
    if (tag_in != "") tag = tag_in;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    cmp(tag, bus_rdata, exp);
  endtask

  task automatic do_wr(input logic [3:0] off, input logic [7:0] d, input logic both);
    @(negedge clk);
    bus_off = off; bus_wr = 1'b1; bus_rd = both; bus_wdata = d;
    if (off == 4'd8) m_cnt = 0;
    else if (off == 4'd6) begin
      if (m_cnt == 4) m_cmd = d; else m_mask = d;
    end
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic chk_mode(input string tag);
    @(posedge clk);
    @(negedge clk);
    cmp(tag, {4'b0, mode_oh}, {4'b0, f_mode(m_cmd)});
    cmp(tag, {6'b0, clk_div}, {6'b0, f_div(m_cmd)});
    cmp(tag, {7'b0, clk_scale23}, {7'b0, (m_cmd[7:5] == 3'b011)});
  endtask

  task automatic unlock();
    do_rd(4'd8, "R5");
    repeat (4) do_rd(4'd6, "R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // reset state
    cmp("R10", bus_rdata, 8'h00);
    chk_mode("R9");
    // unlock sequence, default fill, sticky unlock
    repeat (4) do_rd(4'd6, "R1");
    do_rd(4'd6, "R3");
    do_rd(4'd6, "R2");
    chk_mode("R9");
    // write hidden register, mask untouched
    do_wr(4'd6, 8'hA0, 1'b0);
    chk_mode("R7");
    do_rd(4'd6, "R4");
    do_rd(4'd8, "R5");
    do_rd(4'd6, "R4");
    // write below unlock goes to mask, counter held
    do_wr(4'd6, 8'h55, 1'b0);
    do_rd(4'd6, "R6");
    do_rd(4'd6, "R6");
    do_rd(4'd6, "R6");
    do_rd(4'd6, "R2");
    do_wr(4'd6, 8'hE3, 1'b0);
    chk_mode("R7");
    do_wr(4'd6, 8'h7F, 1'b0);
    chk_mode("R8");
    do_wr(4'd6, 8'h40, 1'b0);
    chk_mode("R9");
    // write to index port clears counter
    do_wr(4'd8, 8'h00, 1'b0);
    do_rd(4'd6, "R5");
    // other offset read, simultaneous strobes act as write
    do_rd(4'd3, "R10");
    do_wr(4'd6, 8'h3C, 1'b1);
    do_rd(4'd6, "R10");
    unlock();
    do_rd(4'd6, "R2");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [7:0] d;
      r = $urandom % 16;
      d = $urandom;
      if ($urandom % 2 == 0) d[7:5] = (r % 2 == 0) ? 3'b011 : 3'b101;
      if (r < 7)       do_rd(4'd6, "");
      else if (r < 10) do_wr(4'd6, d, 1'b0);
      else if (r < 11) do_rd(4'd8, "R5");
      else if (r < 12) do_wr(4'd8, d, 1'b0);
      else if (r < 13) do_rd(4'($urandom % 6), "R10");
      else if (r < 14) do_wr(4'd9 + 4'($urandom % 6), d, 1'b0);
      else             chk_mode("R9");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule